// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Aggregator

This block gathers a parameterised set of level-sensitive peripheral interrupt lines (32, 64 or 128 of them) into one interrupt output per CPU. Each CPU owns a private register bank. A bank holds one enable word and one read-only status word for every group of 32 lines. A CPU's output is raised while any line is both active and enabled in that CPU's bank. To route a line to a CPU, software sets the line's bit in that CPU's bank only.

The block does not rank or encode interrupts. It has no polarity, edge or trigger-type settings, and no set or clear shortcuts. The interrupt handler reads every status word, ANDs each one with its own enable word, and serves the bits that remain. Enable words change only through full-word writes, so software updates them with a read-modify-write. Status words show the synchronised input levels. An interrupt is cleared at its peripheral.

Accesses use a 32-bit register port with separate read and write strobes. Read data appears one clock after the read strobe.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset every enable bit is 0, every `cpu_irq_o` bit is 0 and `rdata_o` is 0.
- R2: Bank c starts at byte address c × (NW × 8), where NW = N_LINES/32. Within the bank, enable word w (lines w×32 … w×32+31, bit b = line w×32+b) sits at byte offset (NW−1−w)×4. A write there replaces the word, and a read returns it.
- R3: Status word w of any bank sits at byte offset NW×4 + (NW−1−w)×4. A read returns the input levels after a two-flop synchroniser, with bit b = line w×32+b.
- R4: Writes to status offsets change no enable bit and no status bit.
- R5: `cpu_irq_o[c]` is the registered OR over all words of (status AND bank c enable). It follows an enable write one clock after the write edge. It follows an input change on the third rising edge after the change.
- R6: A write to bank c leaves the enable words of every other bank unchanged.
- R7: An address is unmapped when its two low bits are not zero or its bank index is N_CPUS or above. A read of an unmapped address returns 0, and a write to one changes nothing.
- R8: `rdata_o` is loaded only on a clock edge where `rd_en_i` is high, and it holds its value at all other times.
- R9: When a read and a write to the same enable word fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | N_LINES | Level-sensitive peripheral interrupt lines |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| cpu_irq_o | output | N_CPUS | Interrupt output, one per CPU |

## Verification
Two functions can fall in the same cycle: a register read and a write to the same enable word. The bench raises both strobes on one edge. It expects the pre-write value on `rdata_o`, then reads again and expects the new value. A second overlap is an enable write landing while input lines are changing. The random phase mixes writes with line changes and checks each CPU output against the model of lines AND enables once the pipeline has settled. Directed steps check the one-cycle latency from an enable write and the three-cycle latency from an input change.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STS  = 2'd2
  } sel_e;

  typedef struct packed {
    sel_e       kind;
    logic [7:0] cpu;
    logic [7:0] word;
  } hit_t;
endpackage

// File: rtl/lia_sync.sv
module lia_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lia_decode.sv
module lia_decode
  import lia_pkg::*;
#(
  parameter int N_CPUS  = 2,
  parameter int N_WORDS = 2,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  localparam int BANK_LSB = $clog2(N_WORDS * 8);
  localparam int BANK_W   = ADDR_W - BANK_LSB;
  localparam int SLOT_W   = BANK_LSB - 2;

  logic [BANK_W-1:0] bank;
  logic [SLOT_W-1:0] slot;

  assign bank = addr_i[ADDR_W-1:BANK_LSB];
  assign slot = addr_i[BANK_LSB-1:2];

  // enable group first, status group after; highest word at lowest address
  always_comb begin
    hit_o = '{kind: SEL_NONE, cpu: 8'd0, word: 8'd0};
    if (addr_i[1:0] == 2'b00 && int'(bank) < N_CPUS) begin
      hit_o.cpu = 8'(bank);
      if (int'(slot) < N_WORDS) begin
        hit_o.kind = SEL_EN;
        hit_o.word = 8'(N_WORDS - 1 - int'(slot));
      end else begin
        hit_o.kind = SEL_STS;
        hit_o.word = 8'(2 * N_WORDS - 1 - int'(slot));
      end
    end
  end
endmodule

// File: rtl/lia_enbank.sv
module lia_enbank
  import lia_pkg::*;
#(
  parameter int N_WORDS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [7:0]                  word_i,
  input  word_t                       wdata_i,
  output logic [N_WORDS*WORD_W-1:0]   en_o
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    word_t en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          en_q <= '0;
      else if (we_i && word_i == 8'(w))     en_q <= wdata_i;
    end
    assign en_o[w*WORD_W +: WORD_W] = en_q;
  end
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
  import lia_pkg::*;
#(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 2,
  parameter int ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_lines_i,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic [N_CPUS-1:0]  cpu_irq_o
);
  localparam int N_WORDS = N_LINES / WORD_W;

  logic [N_LINES-1:0]             sts;
  logic [N_CPUS-1:0][N_LINES-1:0] en_flat;
  hit_t                           hit;
  word_t                          rd_word;
  word_t                          rdata_q;
  logic [N_CPUS-1:0]              irq_q;

  lia_sync #(.WIDTH(N_LINES), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_lines_i),
    .q_o    (sts)
  );

  lia_decode #(.N_CPUS(N_CPUS), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    logic bank_we;
    assign bank_we = wr_en_i && hit.kind == SEL_EN && hit.cpu == 8'(c);

    lia_enbank #(.N_WORDS(N_WORDS)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .word_i  (hit.word),
      .wdata_i (wdata_i),
      .en_o    (en_flat[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[c] <= 1'b0;
      else         irq_q[c] <= |(sts & en_flat[c]);
    end
  end

  always_comb begin
    rd_word = '0;
    case (hit.kind)
      SEL_EN: begin
        for (int c = 0; c < N_CPUS; c++)
          for (int w = 0; w < N_WORDS; w++)
            if (hit.cpu == 8'(c) && hit.word == 8'(w))
              rd_word = en_flat[c][w*WORD_W +: WORD_W];
      end
      SEL_STS: begin
        for (int w = 0; w < N_WORDS; w++)
          if (hit.word == 8'(w)) rd_word = sts[w*WORD_W +: WORD_W];
      end
      default: rd_word = '0;
    endcase
  end

  // read samples pre-write state when both strobes share an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end

  assign rdata_o   = rdata_q;
  assign cpu_irq_o = irq_q;
endmodule

// File: rtl/lia_chk.sv
module lia_chk #(
  parameter int N_LINES = 64,
  parameter int N_CPUS  = 2,
  parameter int ADDR_W  = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           rd_en_i,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [31:0]                    rdata_o,
  input logic [N_CPUS-1:0]              cpu_irq_o,
  input logic [N_LINES-1:0]             sts_i,
  input logic [N_CPUS-1:0][N_LINES-1:0] en_i
);
  localparam int N_WORDS    = N_LINES / 32;
  localparam int BANK_BYTES = N_WORDS * 8;
  localparam int BANK_LSB   = $clog2(BANK_BYTES);

  int   bank_idx;
  logic unmapped;
  logic is_sts;

  always_comb begin
    bank_idx = int'(addr_i >> BANK_LSB);
    unmapped = (addr_i[1:0] != 2'b00) || (bank_idx >= N_CPUS);
    is_sts   = !unmapped && ((int'(addr_i) % BANK_BYTES) >= N_WORDS * 4);
  end

  for (genvar c = 0; c < N_CPUS; c++) begin : g_c
    // R5
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(sts_i & en_i[c])) |=> cpu_irq_o[c]);
    // R5
    irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|(sts_i & en_i[c])) |=> !cpu_irq_o[c]);
    // R6
    bank_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (unmapped || bank_idx != c)) |=> $stable(en_i[c]));
  end

  // R4
  sts_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_sts) |=> $stable(en_i));
  // R7
  unmap_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && unmapped) |=> (rdata_o == 32'd0));
  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind lvl_irq_agg lia_chk #(
  .N_LINES (N_LINES),
  .N_CPUS  (N_CPUS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .cpu_irq_o (cpu_irq_o),
  .sts_i     (sts),
  .en_i      (en_flat)
);

// File: tb/lvl_irq_agg_test.sv
module lvl_irq_agg_test;
  localparam int NL = 64;
  localparam int NC = 2;
  localparam int AW = 8;
  localparam int NW = NL / 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NL-1:0] lines = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC-1:0] irq;

  logic [NC-1:0][NL-1:0] en_m = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lvl_irq_agg #(.N_LINES(NL), .N_CPUS(NC), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lines_i(lines), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cpu_irq_o(irq)
  );

  function automatic logic [AW-1:0] en_addr(int c, int w);
    return AW'(c * NW * 8 + (NW - 1 - w) * 4);
  endfunction

  function automatic logic [AW-1:0] sts_addr(int c, int w);
    return AW'(c * NW * 8 + NW * 4 + (NW - 1 - w) * 4);
  endfunction

  function automatic logic exp_irq(int c);
    return |(lines & en_m[c]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R5 watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old;
    int unsigned seed;
    seed = $urandom(32'd1234);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    rst_ni = 1'b1;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd(en_addr(c, w), d); chk("R1 enable", d, 32'd0);
      end

    // R2 layout and readback
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        en_m[c][w*32 +: 32] = 32'hA5000000 | 32'(c * 16 + w);
        wr(en_addr(c, w), en_m[c][w*32 +: 32]);
      end
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd(en_addr(c, w), d); chk("R2 readback", d, en_m[c][w*32 +: 32]);
      end

    // R3 status layout
    lines = 64'h0123_4567_89AB_CDEF;
    settle();
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd(sts_addr(c, w), d); chk("R3 status", d, lines[w*32 +: 32]);
      end

    // R4 status writes ignored
    wr(sts_addr(0, 0), 32'hFFFF_FFFF);
    wr(sts_addr(1, 1), 32'h0);
    rd(sts_addr(0, 0), d); chk("R4 status kept", d, lines[31:0]);
    rd(en_addr(0, 0), d);  chk("R4 enable kept", d, en_m[0][31:0]);
    rd(en_addr(1, 1), d);  chk("R4 enable kept", d, en_m[1][63:32]);

    // R6 bank isolation
    en_m[0][63:32] = 32'hDEAD_BEEF;
    wr(en_addr(0, 1), en_m[0][63:32]);
    rd(en_addr(1, 1), d); chk("R6 other bank", d, en_m[1][63:32]);
    rd(en_addr(0, 1), d); chk("R6 own bank", d, en_m[0][63:32]);

    // R7 unmapped
    rd(AW'(NC * NW * 8), d); chk("R7 bank oob read", d, 32'd0);
    rd(AW'(1), d);           chk("R7 misaligned read", d, 32'd0);
    wr(AW'(NC * NW * 8 + 4), 32'hFFFF_FFFF);
    wr(AW'(2), 32'hFFFF_FFFF);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd(en_addr(c, w), d); chk("R7 write ignored", d, en_m[c][w*32 +: 32]);
      end

    // R5 latency: clear all, then single line/enable
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        en_m[c][w*32 +: 32] = '0; wr(en_addr(c, w), 32'd0);
      end
    lines = '0;
    settle();
    chk("R5 idle", 32'(irq), 32'd0);
    lines[40] = 1'b1;
    settle();
    chk("R5 masked line", 32'(irq), 32'd0);
    en_m[1][63:32] = 32'h0000_0100;
    wr(en_addr(1, 1), 32'h0000_0100);
    chk("R5 enable +0", 32'(irq), 32'd0);
    @(negedge clk);
    chk("R5 enable +1", 32'(irq), 32'b10);
    @(negedge clk); lines[40] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 drop +2", 32'(irq), 32'b10);
    @(negedge clk);
    chk("R5 drop +3", 32'(irq), 32'b00);

    // R8 hold without read
    lines = 64'hFFFF_FFFF_FFFF_FFFF;
    settle();
    rd(sts_addr(0, 0), d);
    lines = '0;
    settle();
    chk("R8 hold", rdata, 32'hFFFF_FFFF);

    // R9 read and write same word in one cycle
    rd(en_addr(0, 0), old);
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = en_addr(0, 0); wdata = 32'h1357_9BDF;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    chk("R9 old value", rdata, old);
    en_m[0][31:0] = 32'h1357_9BDF;
    rd(en_addr(0, 0), d); chk("R9 new value", d, 32'h1357_9BDF);

    // random mix: R2 R3 R5
    for (int i = 0; i < 300; i++) begin
      int c, w;
      c = int'($urandom_range(NC - 1));
      w = int'($urandom_range(NW - 1));
      en_m[c][w*32 +: 32] = $urandom & $urandom;
      wr(en_addr(c, w), en_m[c][w*32 +: 32]);
      lines = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      settle();
      for (int k = 0; k < NC; k++) chk("R5 random irq", 32'(irq[k]), 32'(exp_irq(k)));
      c = int'($urandom_range(NC - 1));
      w = int'($urandom_range(NW - 1));
      if ($urandom_range(1) == 0) begin
        rd(en_addr(c, w), d); chk("R2 random enable", d, en_m[c][w*32 +: 32]);
      end else begin
        rd(sts_addr(c, w), d); chk("R3 random status", d, lines[w*32 +: 32]);
      end
    end

    summary();
  end
endmodule